// File: doc/BRIEF.md
# Banked Memory Mapper

This block sits between a CPU with 16-bit addresses and the memories behind it. The 64 KB address space is cut into four 16 KB windows. For every CPU access the block decides which device answers. It can be the lower ROM, the upper ROM (with a selectable 8-bit id), one bank of the base 64 KB RAM, or one bank of up to eight 64 KB extended RAM pages. The choice depends on a mapping register, two ROM enables and an upper-ROM select register. The video path reads base RAM directly and does not pass through this block.

Software programs the block with command bytes and ROM-select bytes. Each one is registered on a clock edge and governs the accesses from the next cycle onward. The routing of an access is combinational in the address and strobes. A ROM overlay answers reads only. A write into a ROM window goes to the RAM mapped under that window.

Top module: `mm_mapper`

## Requirements
- R1: A command byte with bits 7:6 = 11 loads the mapping register: bits 5:3 are the extended page p and bits 2:0 the arrangement. No other command byte alters the mapping register.
- R2: Arrangement 0 maps windows 0..3 to base banks 0..3, and ram_page reads 0.
- R3: Arrangement 1 maps window 3 to bank 3 of page p. Windows 0..2 stay on base banks 0..2.
- R4: Arrangement 2 maps window w (0..3) to bank w of page p.
- R5: Arrangement 3 maps window 0 to base bank 0, window 1 to base bank 3, window 2 to base bank 2 and window 3 to bank 3 of page p.
- R6: Arrangements 4..7 map window 1 (0x4000-0x7FFF) to bank (arrangement-4) of page p. All other windows stay on their own base bank.
- R7: A command byte with bits 7:5 = 100 loads the ROM enables. Bit 3 = 0 enables the upper ROM in window 3 and bit 2 = 0 enables the lower ROM in window 0. Command bytes with bits 7:5 = 000, 001, 010, 011 or 101 leave both enables unchanged.
- R8: A write to the ROM-select port loads an 8-bit id at any time. During an upper-ROM read, rom_id shows that id and rom_upper is 1. During a lower-ROM read, rom_id is 0 and rom_upper is 0.
- R9: A read (rd=1, wr=0) in a window whose ROM is enabled asserts rom_cs and not ram_cs. A write to that window asserts ram_cs and ram_we and never rom_cs.
- R10: After reset the arrangement is 0 with page 0, both ROMs are enabled and the ROM-select id is 0.
- R11: With neither rd nor wr asserted, rom_cs, ram_cs and ram_we are all 0.
- R12: A command or ROM-select write changes the routing only from the cycle after the clock edge that captures it. ram_offset always equals address bits 13:0, and ram_ext/ram_page/ram_bank always show the RAM mapped under the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cmd_wr | input | 1 | Command byte valid |
| cmd_data | input | 8 | Command byte |
| romsel_wr | input | 1 | ROM-select byte valid |
| romsel_data | input | 8 | Upper ROM id |
| rom_cs | output | 1 | ROM answers this access |
| rom_upper | output | 1 | Access is to the upper ROM |
| rom_id | output | 8 | Selected upper ROM id (0 otherwise) |
| ram_cs | output | 1 | RAM answers this access |
| ram_we | output | 1 | RAM write |
| ram_ext | output | 1 | 1 = extended RAM, 0 = base RAM |
| ram_page | output | 3 | Extended page (0 for base) |
| ram_bank | output | 2 | 16 KB bank inside base RAM or page |
| ram_offset | output | 14 | Offset inside the bank |

## Verification
A wrong mapping register or ROM enable has no visible effect until an access falls in the window it governs. The bench therefore probes all four windows, with both reads and writes, after every register change, so a corrupted state shows on the bank fields or the chip selects within one cycle. Ignored command classes are followed at once by probes of every window. A stray update would move a bank or switch a ROM on the next access. Latency errors appear as a route change in the same cycle as the register write instead of the one after.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int ADDR_W  = 16;
  localparam int WIN_W   = 2;
  localparam int NWIN    = 1 << WIN_W;
  localparam int OFS_W   = ADDR_W - WIN_W;
  localparam int PAGE_W  = 3;
  localparam int CFG_W   = 3;
  localparam int BANK_W  = 2;
  localparam int CMD_W   = 8;
  localparam int UPPER_OFF_BIT = 3;
  localparam int LOWER_OFF_BIT = 2;

  typedef enum logic [1:0] {CMD_NONE, CMD_ROMCTL, CMD_MAP} cmd_kind_e;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [CFG_W-1:0]  cfg;
  } map_reg_t;

  typedef struct packed {
    logic              ext;
    logic [PAGE_W-1:0] page;
    logic [BANK_W-1:0] bank;
  } phys_bank_t;

  function automatic cmd_kind_e classify(logic [CMD_W-1:0] c);
    if (c[7:6] == 2'b11) return CMD_MAP;
    if (c[7:5] == 3'b100) return CMD_ROMCTL;
    return CMD_NONE;
  endfunction

  function automatic phys_bank_t window_target(map_reg_t m, logic [WIN_W-1:0] win);
    phys_bank_t t;
    t.ext  = 1'b0;
    t.page = '0;
    t.bank = win;
    case (m.cfg)
      3'd1: if (win == 2'd3) t = '{1'b1, m.page, 2'd3};
      3'd2: t = '{1'b1, m.page, win};
      3'd3: begin
        if (win == 2'd1) t.bank = 2'd3;
        else if (win == 2'd3) t = '{1'b1, m.page, 2'd3};
      end
      3'd4, 3'd5, 3'd6, 3'd7: if (win == 2'd1) t = '{1'b1, m.page, m.cfg[1:0]};
      default: ;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/mm_cmd_regs.sv
module mm_cmd_regs
  import mm_pkg::*;
#(
  parameter int ROMID_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_data,
  input  logic               sel_wr,
  input  logic [ROMID_W-1:0] sel_data,
  output map_reg_t           map_q,
  output logic               upper_en,
  output logic               lower_en,
  output logic [ROMID_W-1:0] sel_q
);
  cmd_kind_e kind;
  logic      map_load_ev;
  logic      rom_load_ev;

  assign kind        = classify(cmd_data);
  assign map_load_ev = cmd_wr && (kind == CMD_MAP);
  assign rom_load_ev = cmd_wr && (kind == CMD_ROMCTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q    <= '0;
      upper_en <= 1'b1;
      lower_en <= 1'b1;
      sel_q    <= '0;
    end else begin
      if (map_load_ev) map_q <= map_reg_t'(cmd_data[PAGE_W+CFG_W-1:0]);
      if (rom_load_ev) begin
        upper_en <= ~cmd_data[UPPER_OFF_BIT];
        lower_en <= ~cmd_data[LOWER_OFF_BIT];
      end
      if (sel_wr) sel_q <= sel_data;
    end
  end

  assert_map_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    map_load_ev |=> map_q == $past(cmd_data[5:0]));
  assert_map_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !map_load_ev |=> $stable(map_q));
  assert_rom_ctl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_load_ev |=> (upper_en == !$past(cmd_data[3])) && (lower_en == !$past(cmd_data[2])));
  assert_rom_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_load_ev |=> $stable(upper_en) && $stable(lower_en));
  assert_sel_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(sel_data));
endmodule

// File: rtl/mm_bank_map.sv
module mm_bank_map
  import mm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  map_reg_t         map_q,
  input  logic [WIN_W-1:0] win,
  output phys_bank_t       tgt
);
  phys_bank_t win_tgt [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_tgt[w] = window_target(map_q, WIN_W'(w));
  end

  assign tgt = win_tgt[win];

  assert_linear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    map_q.cfg == 3'd0 |-> !tgt.ext && tgt.bank == win && tgt.page == '0);
  assert_top_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_q.cfg == 3'd1 |-> tgt.ext == (win == 2'd3));
  assert_all_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    map_q.cfg == 3'd2 |-> tgt.ext && tgt.page == map_q.page && tgt.bank == win);
  assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    map_q.cfg == 3'd3 && win == 2'd1 |-> !tgt.ext && tgt.bank == 2'd3);
  assert_mid_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    map_q.cfg[2] && win != 2'd1 |-> !tgt.ext && tgt.bank == win);
endmodule

// File: rtl/mm_route.sv
module mm_route
  import mm_pkg::*;
#(
  parameter int ROMID_W   = 8,
  parameter int UPPER_WIN = 3,
  parameter int LOWER_WIN = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic               upper_en,
  input  logic               lower_en,
  input  logic [ROMID_W-1:0] sel_q,
  input  phys_bank_t         tgt,
  output logic               rom_cs,
  output logic               rom_upper,
  output logic [ROMID_W-1:0] rom_id,
  output logic               ram_cs,
  output logic               ram_we,
  output logic               ram_ext,
  output logic [PAGE_W-1:0]  ram_page,
  output logic [BANK_W-1:0]  ram_bank,
  output logic [OFS_W-1:0]   ram_offset
);
  logic [WIN_W-1:0] win;
  logic up_hit, lo_hit, rd_only;

  assign win     = addr[ADDR_W-1 -: WIN_W];
  assign up_hit  = upper_en && (win == WIN_W'(UPPER_WIN));
  assign lo_hit  = lower_en && (win == WIN_W'(LOWER_WIN));
  assign rd_only = rd && !wr;

  always_comb begin
    rom_cs     = rd_only && (up_hit || lo_hit);
    rom_upper  = rom_cs && up_hit;
    rom_id     = rom_upper ? sel_q : '0;
    ram_cs     = (rd || wr) && !rom_cs;
    ram_we     = ram_cs && wr;
    ram_ext    = tgt.ext;
    ram_page   = tgt.page;
    ram_bank   = tgt.bank;
    ram_offset = addr[OFS_W-1:0];
  end

  assert_write_ram_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !rom_cs && ram_cs && ram_we);
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd && !wr |-> !rom_cs && !ram_cs && !ram_we);
  assert_upper_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs && rom_upper |-> rom_id == sel_q);
endmodule

// File: rtl/mm_mapper.sv
module mm_mapper
  import mm_pkg::*;
#(
  parameter int ROMID_W   = 8,
  parameter int UPPER_WIN = 3,
  parameter int LOWER_WIN = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic               cmd_wr,
  input  logic [7:0]         cmd_data,
  input  logic               romsel_wr,
  input  logic [ROMID_W-1:0] romsel_data,
  output logic               rom_cs,
  output logic               rom_upper,
  output logic [ROMID_W-1:0] rom_id,
  output logic               ram_cs,
  output logic               ram_we,
  output logic               ram_ext,
  output logic [2:0]         ram_page,
  output logic [1:0]         ram_bank,
  output logic [13:0]        ram_offset
);
  map_reg_t           map_q;
  logic               upper_en, lower_en;
  logic [ROMID_W-1:0] sel_q;
  phys_bank_t         tgt;
  logic [WIN_W-1:0]   cur_win;

  assign cur_win = cpu_addr[ADDR_W-1 -: WIN_W];

  mm_cmd_regs #(.ROMID_W(ROMID_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .sel_wr(romsel_wr), .sel_data(romsel_data),
    .map_q(map_q), .upper_en(upper_en), .lower_en(lower_en), .sel_q(sel_q)
  );

  mm_bank_map u_map (
    .clk(clk), .rst_n(rst_n), .map_q(map_q), .win(cur_win), .tgt(tgt)
  );

  mm_route #(.ROMID_W(ROMID_W), .UPPER_WIN(UPPER_WIN), .LOWER_WIN(LOWER_WIN)) u_route (
    .clk(clk), .rst_n(rst_n),
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .upper_en(upper_en), .lower_en(lower_en), .sel_q(sel_q), .tgt(tgt),
    .rom_cs(rom_cs), .rom_upper(rom_upper), .rom_id(rom_id),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_ext(ram_ext),
    .ram_page(ram_page), .ram_bank(ram_bank), .ram_offset(ram_offset)
  );
endmodule

// File: tb/mm_mapper_bench.sv
module mm_mapper_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_data = '0;
  logic romsel_wr = 1'b0;
  logic [7:0] romsel_data = '0;
  logic rom_cs, rom_upper, ram_cs, ram_we, ram_ext;
  logic [7:0] rom_id;
  logic [2:0] ram_page;
  logic [1:0] ram_bank;
  logic [13:0] ram_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] m_cfg = '0, m_page = '0;
  logic m_uen = 1'b1, m_len = 1'b1;
  logic [7:0] m_sel = '0;

  always #2.5 clk = ~clk;

  mm_mapper u_mm_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cmd_wr(cmd_wr), .cmd_data(cmd_data), .romsel_wr(romsel_wr), .romsel_data(romsel_data),
    .rom_cs(rom_cs), .rom_upper(rom_upper), .rom_id(rom_id), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_ext(ram_ext), .ram_page(ram_page), .ram_bank(ram_bank), .ram_offset(ram_offset)
  );

  function automatic logic [31:0] expect_vec(logic [15:0] a, logic rd, logic wr);
    logic [1:0] w = a[15:14];
    logic ext = 1'b0;
    logic [2:0] pg = 3'd0;
    logic [1:0] bk = w;
    logic hit, up, rc;
    if (m_cfg == 3'd2) begin ext = 1'b1; pg = m_page; end
    else if (m_cfg == 3'd1 && w == 2'd3) begin ext = 1'b1; pg = m_page; end
    else if (m_cfg == 3'd3) begin
      if (w == 2'd1) bk = 2'd3;
      if (w == 2'd3) begin ext = 1'b1; pg = m_page; end
    end else if (m_cfg >= 3'd4 && w == 2'd1) begin
      ext = 1'b1; pg = m_page; bk = 2'(m_cfg - 3'd4);
    end
    hit = rd && !wr && ((w == 2'd3 && m_uen) || (w == 2'd0 && m_len));
    up  = hit && (w == 2'd3);
    rc  = (rd || wr) && !hit;
    return {hit, up, up ? m_sel : 8'h00, rc, rc && wr, ext, pg, bk, a[13:0]};
  endfunction

  function automatic logic [31:0] dut_vec();
    return {rom_cs, rom_upper, rom_id, ram_cs, ram_we, ram_ext, ram_page, ram_bank, ram_offset};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic probe(string req, logic [15:0] a, logic rd, logic wr);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    #1;
    chk(req, dut_vec(), expect_vec(a, rd, wr));
  endtask

  task automatic model_cmd(logic [7:0] v);
    if (v[7:6] == 2'b11) begin m_cfg = v[2:0]; m_page = v[5:3]; end
    else if (v[7:5] == 3'b100) begin m_uen = !v[3]; m_len = !v[2]; end
  endtask

  task automatic send_cmd(logic [7:0] v);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_data = v;
    @(negedge clk);
    cmd_wr = 1'b0;
    model_cmd(v);
  endtask

  task automatic send_sel(logic [7:0] v);
    @(negedge clk);
    romsel_wr = 1'b1; romsel_data = v;
    @(negedge clk);
    romsel_wr = 1'b0;
    m_sel = v;
  endtask

  task automatic sweep(string req);
    for (int w = 0; w < 4; w++) begin
      probe(req, {2'(w), 14'h1A5 + 14'(w)}, 1'b1, 1'b0);
      probe(req, {2'(w), 14'h3FFF - 14'(w)}, 1'b0, 1'b1);
    end
  endtask

  task automatic t_reset();
    probe("R10", 16'h0000, 1'b1, 1'b0);
    chk("R10 lower rom", {31'd0, rom_cs}, 32'd1);
    probe("R10", 16'hC123, 1'b1, 1'b0);
    chk("R10 upper id0", {23'd0, rom_upper, rom_id}, {23'd0, 1'b1, 8'h00});
    probe("R10", 16'h4000, 1'b1, 1'b0);
    probe("R10", 16'h8000, 1'b0, 1'b1);
  endtask

  task automatic t_configs();
    send_cmd(8'h8C);
    for (int c = 0; c < 8; c++) begin
      string tag;
      case (c)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R4";
        3: tag = "R5";
        default: tag = "R6";
      endcase
      send_cmd({2'b11, 3'(c ^ 5), 3'(c)});
      sweep(tag);
    end
  endtask

  task automatic t_map_load();
    send_cmd(8'hFA);
    sweep("R1 page7");
    chk("R1 page7 direct", {29'd0, m_page}, 32'd7);
    send_cmd(8'hC2);
    sweep("R1 page0");
    send_cmd(8'h3F);
    send_cmd(8'h5F);
    send_cmd(8'hA0);
    send_cmd(8'h85);
    sweep("R1 ignore");
  endtask

  task automatic t_rom_ctl();
    send_cmd(8'h80);
    sweep("R7 both on");
    send_cmd(8'h84);
    sweep("R7 upper only");
    send_cmd(8'h88);
    sweep("R7 lower only");
    send_cmd(8'hA0);
    send_cmd(8'h2C);
    send_cmd(8'h6C);
    sweep("R7 ignored");
    send_cmd(8'h80);
    probe("R9 write under upper", 16'hFFFF, 1'b0, 1'b1);
    probe("R9 write under lower", 16'h0001, 1'b0, 1'b1);
    probe("R9 read lower", 16'h3FFF, 1'b1, 1'b0);
    probe("R9 rd+wr", 16'hC000, 1'b1, 1'b1);
  endtask

  task automatic t_sel();
    send_sel(8'hFF);
    probe("R8 id FF", 16'hC000, 1'b1, 1'b0);
    send_sel(8'h07);
    probe("R8 id 07", 16'hE000, 1'b1, 1'b0);
    probe("R8 lower id0", 16'h2000, 1'b1, 1'b0);
    send_cmd(8'h88);
    send_sel(8'h42);
    send_cmd(8'h80);
    probe("R8 id kept", 16'hC000, 1'b1, 1'b0);
  endtask

  task automatic t_idle();
    for (int w = 0; w < 4; w++) probe("R11", {2'(w), 14'h0}, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    send_cmd(8'h80);
    send_cmd(8'hC0);
    @(negedge clk);
    cpu_addr = 16'h4010; cpu_rd = 1'b1; cpu_wr = 1'b0;
    cmd_wr = 1'b1; cmd_data = 8'hE6;
    #1;
    chk("R12 before edge", dut_vec(), expect_vec(16'h4010, 1'b1, 1'b0));
    @(negedge clk);
    cmd_wr = 1'b0;
    model_cmd(8'hE6);
    #1;
    chk("R12 after edge", dut_vec(), expect_vec(16'h4010, 1'b1, 1'b0));
    chk("R12 ext bank", {29'd0, ram_ext, ram_bank}, {29'd0, 1'b1, 2'd2});
    @(negedge clk);
    cpu_addr = 16'hC000;
    romsel_wr = 1'b1; romsel_data = 8'h99;
    #1;
    chk("R12 sel before", dut_vec(), expect_vec(16'hC000, 1'b1, 1'b0));
    @(negedge clk);
    romsel_wr = 1'b0; m_sel = 8'h99;
    #1;
    chk("R12 sel after", dut_vec(), expect_vec(16'hC000, 1'b1, 1'b0));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_configs();
    t_map_load();
    t_rom_ctl();
    t_sel();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule